// File: doc/BRIEF.md
# Packed 128-bit SIMD Vector ALU

This block is the arithmetic stage of a single thread's vector datapath. Each accepted request carries two 128-bit source vectors, a 128-bit accumulator vector and a 3-bit operation code. The block computes the chosen packed operation and presents it on a registered 128-bit result with a one-cycle valid strobe. A vector can be read as sixteen 8-bit lanes, where lane i occupies bits [8i+7:8i], or as four 32-bit lanes, where lane k occupies bits [32k+31:32k].

The 8-bit operations are add, multiply keeping the low byte, and multiply-accumulate. Each 8-bit lane wraps on its own. A nibble dot-product splits every 32-bit lane of both sources into eight signed 4-bit values. It adds the sum of their pairwise products to the matching accumulator lane.

Three codes give fixed integer placeholders for floating-point add, multiply and fused multiply-add on 32-bit lanes. These are not IEEE-correct. The last code is a prefetch hint and has no architectural effect. Decode, register storage and memory access are handled by neighbouring blocks.

Top module: `vsimd_alu`

## Requirements
- R1: While reset (rst_n low) is applied and after its release, out_valid is 0 and result is all zeros until the first accepted request.
- R2: Code 000 (add): each 8-bit lane of result is (a_lane + b_lane) mod 256. No carry crosses a lane boundary.
- R3: Code 001 (multiply-low): each 8-bit lane of result is (a_lane * b_lane) mod 256, treating the lanes as unsigned.
- R4: Code 010 (multiply-accumulate): each 8-bit lane of result is (a_lane * b_lane + acc_lane) mod 256. An all-zero accumulator gives the plain low product.
- R5: Code 011 (nibble dot-product): for each 32-bit lane k, the result is acc_k plus the sum over j=0..7 of the product of the nibbles at bits [32k+4j+3:32k+4j] of a and of b, each read as two's-complement in -8..7. The sum wraps modulo 2^32, and the four lanes are independent.
- R6: Code 100 (float-add placeholder): each 32-bit lane of result is (a_k + b_k) mod 2^32.
- R7: Code 101 (float-multiply placeholder) gives (a_k * b_k) mod 2^32 per 32-bit lane. Code 110 (fused placeholder) gives (a_k * b_k + acc_k) mod 2^32 per 32-bit lane.
- R8: Code 111 (prefetch hint): out_valid stays 0 in the following cycle and result keeps its previous value.
- R9: A request accepted at a clock edge (in_valid high, code not 111) makes out_valid high and result correct after that same edge, for exactly one cycle per request. Back-to-back requests each produce their own result. Without a request, out_valid is 0 and result is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present this cycle |
| op | input | 3 | Operation code |
| src_a | input | 128 | First source vector |
| src_b | input | 128 | Second source vector |
| acc | input | 128 | Accumulator vector |
| out_valid | output | 1 | Result strobe, one cycle per request |
| result | output | 128 | Registered result vector |

## Verification
Byte operations are driven with all-0xFF plus 0x01 vectors, which reveal any carry that leaks between lanes, and with distinct per-lane patterns, which reveal swapped or mis-indexed lanes. The dot-product gets all -8 nibbles, to reach the largest positive sum, a mix of signs, and an accumulator near 2^32, to test 32-bit wrap. Zero accumulators separate multiply-accumulate from a plain multiply. The prefetch code and idle cycles follow real results, so a changed or strobed output can be told apart from one that is correctly held. Back-to-back requests with different codes test that each result is registered in its own cycle.

// File: rtl/vsimd_pkg.sv
package vsimd_pkg;
  localparam int VEC_W  = 128;
  localparam int BYTE_W = 8;
  localparam int WORD_W = 32;
  localparam int NIB_W  = 4;

  typedef enum logic [2:0] {
    OP_BADD   = 3'b000,
    OP_BMUL   = 3'b001,
    OP_BMAC   = 3'b010,
    OP_NDOT   = 3'b011,
    OP_FADD   = 3'b100,
    OP_FMUL   = 3'b101,
    OP_FFMA   = 3'b110,
    OP_PFETCH = 3'b111
  } vop_e;

  // 8-bit lane arithmetic, wraps modulo 256
  function automatic logic [BYTE_W-1:0] byte_calc(input logic [1:0] sel,
      input logic [BYTE_W-1:0] a, input logic [BYTE_W-1:0] b,
      input logic [BYTE_W-1:0] c);
    logic [BYTE_W-1:0] r;
    case (sel)
      2'b00:   r = a + b;
      2'b01:   r = a * b;
      default: r = a * b + c;
    endcase
    return r;
  endfunction

  // signed nibble dot-product into one 32-bit lane
  function automatic logic [WORD_W-1:0] nib_dot(input logic [WORD_W-1:0] a,
      input logic [WORD_W-1:0] b, input logic [WORD_W-1:0] c);
    logic [WORD_W-1:0] s;
    logic signed [NIB_W-1:0] na, nb;
    logic signed [2*NIB_W-1:0] p;
    s = c;
    for (int j = 0; j < WORD_W/NIB_W; j++) begin
      na = a[NIB_W*j +: NIB_W];
      nb = b[NIB_W*j +: NIB_W];
      p  = na * nb;
      s  = s + {{(WORD_W-2*NIB_W){p[2*NIB_W-1]}}, p};
    end
    return s;
  endfunction

  // 32-bit placeholder arithmetic for float codes
  function automatic logic [WORD_W-1:0] word_stub(input logic [1:0] sel,
      input logic [WORD_W-1:0] a, input logic [WORD_W-1:0] b,
      input logic [WORD_W-1:0] c);
    logic [WORD_W-1:0] r;
    case (sel)
      2'b00:   r = a + b;
      2'b01:   r = a * b;
      default: r = a * b + c;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/vsimd_byte_lanes.sv
module vsimd_byte_lanes
  import vsimd_pkg::*;
#(
  parameter int DATA_W = VEC_W,
  parameter int LANE_W = BYTE_W
) (
  input  logic [1:0]        sel,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic [DATA_W-1:0] c,
  output logic [DATA_W-1:0] y
);
  localparam int NLANE = DATA_W / LANE_W;

  for (genvar i = 0; i < NLANE; i++) begin : g_lane
    assign y[LANE_W*i +: LANE_W] = byte_calc(sel, a[LANE_W*i +: LANE_W],
                                             b[LANE_W*i +: LANE_W],
                                             c[LANE_W*i +: LANE_W]);
  end
endmodule

// File: rtl/vsimd_nibble_dot.sv
module vsimd_nibble_dot
  import vsimd_pkg::*;
#(
  parameter int DATA_W = VEC_W,
  parameter int LANE_W = WORD_W
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic [DATA_W-1:0] c,
  output logic [DATA_W-1:0] y
);
  localparam int NLANE = DATA_W / LANE_W;

  for (genvar k = 0; k < NLANE; k++) begin : g_lane
    assign y[LANE_W*k +: LANE_W] = nib_dot(a[LANE_W*k +: LANE_W],
                                           b[LANE_W*k +: LANE_W],
                                           c[LANE_W*k +: LANE_W]);
  end
endmodule

// File: rtl/vsimd_word_stub.sv
module vsimd_word_stub
  import vsimd_pkg::*;
#(
  parameter int DATA_W = VEC_W,
  parameter int LANE_W = WORD_W
) (
  input  logic [1:0]        sel,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic [DATA_W-1:0] c,
  output logic [DATA_W-1:0] y
);
  localparam int NLANE = DATA_W / LANE_W;

  for (genvar k = 0; k < NLANE; k++) begin : g_lane
    assign y[LANE_W*k +: LANE_W] = word_stub(sel, a[LANE_W*k +: LANE_W],
                                             b[LANE_W*k +: LANE_W],
                                             c[LANE_W*k +: LANE_W]);
  end
endmodule

// File: rtl/vsimd_alu.sv
module vsimd_alu
  import vsimd_pkg::*;
#(
  parameter int DATA_W = VEC_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [2:0]        op,
  input  logic [DATA_W-1:0] src_a,
  input  logic [DATA_W-1:0] src_b,
  input  logic [DATA_W-1:0] acc,
  output logic              out_valid,
  output logic [DATA_W-1:0] result
);
  logic [DATA_W-1:0] byte_y, dot_y, word_y, next_y;
  logic [DATA_W-1:0] res_q;
  logic              vld_q;
  logic              is_prefetch;
  logic              take;

  assign is_prefetch = (op == OP_PFETCH);
  assign take        = in_valid && !is_prefetch;

  vsimd_byte_lanes #(.DATA_W(DATA_W), .LANE_W(BYTE_W)) u_bytes (
    .sel(op[1:0]), .a(src_a), .b(src_b), .c(acc), .y(byte_y));

  vsimd_nibble_dot #(.DATA_W(DATA_W), .LANE_W(WORD_W)) u_dot (
    .a(src_a), .b(src_b), .c(acc), .y(dot_y));

  vsimd_word_stub #(.DATA_W(DATA_W), .LANE_W(WORD_W)) u_words (
    .sel(op[1:0]), .a(src_a), .b(src_b), .c(acc), .y(word_y));

  always_comb begin
    case (op)
      OP_BADD, OP_BMUL, OP_BMAC: next_y = byte_y;
      OP_NDOT:                   next_y = dot_y;
      OP_FADD, OP_FMUL, OP_FFMA: next_y = word_y;
      default:                   next_y = res_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      res_q <= '0;
    end else begin
      vld_q <= take;
      if (take) res_q <= next_y;
    end
  end

  assign out_valid = vld_q;
  assign result    = res_q;

  // R9: one-cycle latency on accepted requests
  p_valid_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> out_valid);

  // R9: idle cycles hold the result and drop the strobe
  p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(result)));

  // R8: prefetch hint leaves the destination untouched
  p_prefetch_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && is_prefetch) |=> (!out_valid && $stable(result)));

  // R2: adding a zero vector returns the first source
  p_add_identity_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == OP_BADD && src_b == '0) |=> (result == $past(src_a)));

  // R5: a zero source makes the dot-product return the accumulator
  p_dot_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == OP_NDOT && src_a == '0) |=> (result == $past(acc)));

  // R3: multiply by zero clears every lane
  p_mul_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == OP_BMUL && src_b == '0) |=> (result == '0));
endmodule

// File: tb/vsimd_alu_bench.sv
`timescale 1ns/1ps
module vsimd_alu_bench;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic [2:0]   op = 3'b000;
  logic [127:0] src_a = '0, src_b = '0, acc = '0;
  logic         out_valid;
  logic [127:0] result;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  vsimd_alu u_vsimd_alu (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op),
    .src_a(src_a), .src_b(src_b), .acc(acc),
    .out_valid(out_valid), .result(result));

  // reference model, written from the requirements
  function automatic logic [127:0] model(input logic [2:0] o,
      input logic [127:0] a, input logic [127:0] b, input logic [127:0] c);
    logic [127:0] r = '0;
    if (o <= 3'd2) begin
      for (int i = 0; i < 16; i++) begin
        int x = int'((a >> (8*i)) & 128'hFF);
        int y = int'((b >> (8*i)) & 128'hFF);
        int z = int'((c >> (8*i)) & 128'hFF);
        int v = (o == 3'd0) ? x + y : (o == 3'd1) ? x * y : x * y + z;
        r[8*i +: 8] = 8'(v % 256);
      end
    end else if (o == 3'd3) begin
      for (int k = 0; k < 4; k++) begin
        longint s = longint'(c[32*k +: 32]);
        for (int j = 0; j < 8; j++) begin
          int x = int'(a[32*k + 4*j +: 4]);
          int y = int'(b[32*k + 4*j +: 4]);
          if (x > 7) x = x - 16;
          if (y > 7) y = y - 16;
          s = s + longint'(x * y);
        end
        r[32*k +: 32] = 32'(s);
      end
    end else begin
      for (int k = 0; k < 4; k++) begin
        longint unsigned x = 64'(a[32*k +: 32]);
        longint unsigned y = 64'(b[32*k +: 32]);
        longint unsigned z = 64'(c[32*k +: 32]);
        longint unsigned v = (o == 3'd4) ? x + y : (o == 3'd5) ? x * y : x * y + z;
        r[32*k +: 32] = v[31:0];
      end
    end
    return r;
  endfunction

  task automatic check(input string req, input logic [127:0] got,
                       input logic [127:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  // drive one request, release it, then check the registered output
  task automatic run_op(input string req, input logic [2:0] o,
      input logic [127:0] a, input logic [127:0] b, input logic [127:0] c);
    @(negedge clk);
    in_valid = 1'b1; op = o; src_a = a; src_b = b; acc = c;
    @(negedge clk);
    in_valid = 1'b0;
    check(req, {127'd0, out_valid}, 128'd1);
    check(req, result, model(o, a, b, c));
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R1", {127'd0, out_valid}, 128'd0);
    check("R1", result, '0);
  endtask

  task automatic t_byte_add();
    run_op("R2", 3'b000, {16{8'hFF}}, {16{8'h01}}, '0);
    run_op("R2", 3'b000, 128'h0F1E2D3C4B5A69788796A5B4C3D2E1F0,
                         128'hF0E1D2C3B4A5968778695A4B3C2D1E0F, '0);
    run_op("R2", 3'b000, 128'h80FF7F0180FF7F0180FF7F0180FF7F01,
                         128'h80017F0280017F0280017F0280017F02, '0);
  endtask

  task automatic t_byte_mul();
    run_op("R3", 3'b001, 128'h0102030405060708090A0B0C0D0E0F10,
                         128'h100F0E0D0C0B0A090807060504030201, '0);
    run_op("R3", 3'b001, {16{8'hFF}}, {16{8'hFF}}, '0);
  endtask

  task automatic t_byte_mac();
    run_op("R4", 3'b010, 128'h11223344556677889900AABBCCDDEEFF,
                         128'h0302010003020100030201000302FF80,
                         128'hFFEEDDCCBBAA99887766554433221100);
    run_op("R4", 3'b010, 128'h11223344556677889900AABBCCDDEEFF,
                         128'h0302010003020100030201000302FF80, '0);
  endtask

  task automatic t_dot();
    run_op("R5", 3'b011, {32{4'h8}}, {32{4'h8}}, '0);
    run_op("R5", 3'b011, 128'h7F81_2E3D_9A0B_C4D5_6677_8899_F0E1_1234,
                         128'h8877_6655_4433_2211_0FED_CBA9_1357_9BDF,
                         128'h00000005_FFFFFFF0_80000000_12345678);
    run_op("R5", 3'b011, {32{4'h7}}, {32{4'h7}}, {4{32'hFFFFFE80}});
  endtask

  task automatic t_fp_stubs();
    run_op("R6", 3'b100, 128'hFFFFFFFF_80000000_12345678_00000001,
                         128'h00000001_80000000_87654321_FFFFFFFF, '0);
    run_op("R7", 3'b101, 128'h00010001_FFFFFFFF_00001234_7FFFFFFF,
                         128'h00010001_FFFFFFFF_00005678_00000002, '0);
    run_op("R7", 3'b110, 128'h00010001_FFFFFFFF_00001234_7FFFFFFF,
                         128'h00010001_FFFFFFFF_00005678_00000002,
                         128'h00000001_00000010_FFFFFFFF_00000003);
  endtask

  task automatic t_prefetch();
    logic [127:0] held;
    run_op("R8", 3'b000, 128'h1, 128'h2, '0);
    held = result;
    @(negedge clk);
    in_valid = 1'b1; op = 3'b111; src_a = {16{8'h55}}; src_b = {16{8'hAA}};
    acc = {16{8'h33}};
    @(negedge clk);
    in_valid = 1'b0;
    check("R8", {127'd0, out_valid}, 128'd0);
    check("R8", result, held);
  endtask

  task automatic t_idle_and_b2b();
    logic [127:0] a1 = 128'hDEADBEEF_01234567_89ABCDEF_CAFEF00D;
    logic [127:0] b1 = 128'h13579BDF_2468ACE0_FEDCBA98_76543210;
    logic [127:0] held;
    run_op("R9", 3'b001, a1, b1, '0);
    held = result;
    @(negedge clk);
    check("R9", {127'd0, out_valid}, 128'd0);
    check("R9", result, held);
    // back-to-back: add then dot then float add
    in_valid = 1'b1; op = 3'b000; src_a = a1; src_b = b1; acc = '0;
    @(negedge clk);
    check("R9", result, model(3'b000, a1, b1, '0));
    op = 3'b011; acc = 128'h5;
    @(negedge clk);
    check("R9", {127'd0, out_valid}, 128'd1);
    check("R9", result, model(3'b011, a1, b1, 128'h5));
    op = 3'b100;
    @(negedge clk);
    in_valid = 1'b0;
    check("R9", result, model(3'b100, a1, b1, 128'h5));
    @(negedge clk);
    check("R9", {127'd0, out_valid}, 128'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_byte_add();
    t_byte_mul();
    t_byte_mac();
    t_dot();
    t_fp_stubs();
    t_prefetch();
    t_idle_and_b2b();
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog got=timeout exp=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule